// File: doc/BRIEF.md
# Serial Gain-Code Loader

This block takes a gain setting from a three-wire serial port and holds it in a gain register. The register drives the control bus of an attenuator. The port has a serial clock, a serial data line and an active-low load enable. The block samples all three pins with a faster system clock. It detects their edges in that clock domain, so the serial port needs no clock tree of its own.

While the load enable is low, each rising edge of the serial clock shifts one data bit into an 8-bit shift register, most significant bit first. When the load enable rises, the received word is cleaned up and committed to the gain register, and a one-cycle strobe is raised. Cleaning up the word means three steps:
- the upper two bits are dropped;
- codes above the top of the range are clamped down to it;
- code 0 is raised to the bottom of the range.

Beside the 6-bit code, the block gives the same setting as a signed gain in half-dB steps. It also folds the transmit-enable and active-low sleep inputs into a 2-bit power-mode output. These two inputs never touch the stored gain.

Top module: `gain_serial_loader`

## Requirements
- R1: After reset the gain code is 1, the half-dB gain is -51, the commit strobe is low and the power mode is 2'b00 (sleep).
- R2: While the load enable is low, each rising edge of the serial clock shifts in one data bit, most significant bit first. On the rising edge of the load enable, the low 6 bits of the last 8 bits received become the gain code (word 37 gives code 37).
- R3: Bits 7 and 6 of the received word are discarded, so word 75 gives code 11 and word 181 gives code 53.
- R4: Codes 61, 62 and 63 are stored as code 60.
- R5: Code 0 is stored as code 1. This includes words such as 64, whose low 6 bits are zero.
- R6: The half-dB gain output equals 2*code-53 as an 8-bit two's-complement value: -51 at code 1 and +67 at code 60.
- R7: The commit strobe is high for exactly one system clock cycle for each rising edge of the load enable, and at no other time.
- R8: Serial clock edges that arrive while the load enable is high shift nothing. A later load with no serial clock edges commits the previously received word again.
- R9: The gain code does not change while a word is being shifted in. It changes only in the cycle in which the commit strobe is high.
- R10: The power mode is 2'b00 (sleep) whenever the sleep input is low, whatever the transmit enable is. With the sleep input high, it is 2'b01 (standby) when the transmit enable is low and 2'b10 (transmit) when it is high. Neither input changes the gain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_dat_i | input | 1 | Serial data pin, MSB first, asynchronous |
| load_n_i | input | 1 | Active-low load enable; its rising edge commits the word |
| tx_on_i | input | 1 | Transmit enable, high to transmit |
| awake_n_i | input | 1 | Sleep input, low puts the block's power mode into sleep |
| gain_code_o | output | 6 | Committed gain code, 1 to 60 |
| gain_hdb_o | output | 8 | Committed gain in signed half-dB units |
| commit_o | output | 1 | One-cycle strobe when a new code is committed |
| pwr_mode_o | output | 2 | 00 sleep, 01 standby, 10 transmit |

## Verification
The case that is hardest to reach from the ports is the proof that serial clock edges arriving with the load enable high are really discarded. A shift register that wrongly accepts them is hidden until a later commit. The stimulus first commits a known word. It then toggles the serial clock with data held at one while the enable is high. Finally it drops and raises the enable with no clock edges in between, so the shift register's contents come out through the gain code unchanged. The gain code is also read in the middle of a word, to show that shifting leaves the committed value alone until the enable rises.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

  typedef enum logic [1:0] {
    PM_SLEEP    = 2'b00,
    PM_STANDBY  = 2'b01,
    PM_TRANSMIT = 2'b10
  } pwr_mode_e;

endpackage

// File: rtl/gsl_sync.sv
module gsl_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gsl_shift.sv
module gsl_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s_i,
  input  logic              sdat_s_i,
  input  logic              load_n_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);

  logic              sclk_prev_q;
  logic              load_prev_q;
  logic [WORD_W-1:0] shreg_q;
  logic              sclk_rise;

  assign sclk_rise = sclk_s_i & ~sclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b1;
      shreg_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      load_prev_q <= load_n_s_i;
      if (sclk_rise && !load_n_s_i) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdat_s_i};
      end
    end
  end

  assign word_o   = shreg_q;
  assign commit_o = load_n_s_i & ~load_prev_q;

endmodule

// File: rtl/gsl_decode.sv
module gsl_decode #(
  parameter int WORD_W   = 8,
  parameter int CODE_W   = 6,
  parameter int CODE_MIN = 1,
  parameter int CODE_MAX = 60,
  parameter int HDB_W    = 8,
  parameter int HDB_OFS  = 53
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o,
  output logic [HDB_W-1:0]  hdb_o
);

  logic [CODE_W-1:0] raw;
  int                hdb_int;

  assign raw = word_i[CODE_W-1:0];

  always_comb begin
    if (int'(raw) < CODE_MIN) begin
      code_o = CODE_W'(CODE_MIN);
    end else if (int'(raw) > CODE_MAX) begin
      code_o = CODE_W'(CODE_MAX);
    end else begin
      code_o = raw;
    end
    hdb_int = 2 * int'(code_o) - HDB_OFS;
    hdb_o   = hdb_int[HDB_W-1:0];
  end

endmodule

// File: rtl/gsl_pwr.sv
module gsl_pwr
  import gsl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_s_i,
  input  logic      awake_s_i,
  output pwr_mode_e mode_o
);

  pwr_mode_e mode_d;

  always_comb begin
    if (!awake_s_i) begin
      mode_d = PM_SLEEP;
    end else if (tx_s_i) begin
      mode_d = PM_TRANSMIT;
    end else begin
      mode_d = PM_STANDBY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= PM_SLEEP;
    end else begin
      mode_o <= mode_d;
    end
  end

endmodule

// File: rtl/gain_serial_loader.sv
module gain_serial_loader
  import gsl_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int CODE_W       = 6,
  parameter int CODE_MIN     = 1,
  parameter int CODE_MAX     = 60,
  parameter int HDB_W        = 8,
  parameter int GAIN_MIN_HDB = -51,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              load_n_i,
  input  logic              tx_on_i,
  input  logic              awake_n_i,
  output logic [CODE_W-1:0] gain_code_o,
  output logic [HDB_W-1:0]  gain_hdb_o,
  output logic              commit_o,
  output logic [1:0]        pwr_mode_o
);

  localparam int HDB_OFS = 2 * CODE_MIN - GAIN_MIN_HDB;
  localparam int PIN_N   = 5;
  localparam logic [HDB_W-1:0] RST_HDB = HDB_W'(GAIN_MIN_HDB);
  // pin order: awake, tx, load_n, data, clock; load_n idles high
  localparam logic [PIN_N-1:0] PIN_RST = 5'b00100;

  logic [PIN_N-1:0]  pins_s;
  logic [WORD_W-1:0] word;
  logic              commit_pulse;
  logic [CODE_W-1:0] dec_code;
  logic [HDB_W-1:0]  dec_hdb;
  pwr_mode_e         mode;

  gsl_sync #(
    .W      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({awake_n_i, tx_on_i, load_n_i, ser_dat_i, ser_clk_i}),
    .q_o(pins_s)
  );

  gsl_shift #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s_i  (pins_s[0]),
    .sdat_s_i  (pins_s[1]),
    .load_n_s_i(pins_s[2]),
    .word_o    (word),
    .commit_o  (commit_pulse)
  );

  gsl_decode #(
    .WORD_W  (WORD_W),
    .CODE_W  (CODE_W),
    .CODE_MIN(CODE_MIN),
    .CODE_MAX(CODE_MAX),
    .HDB_W   (HDB_W),
    .HDB_OFS (HDB_OFS)
  ) u_decode (
    .word_i(word),
    .code_o(dec_code),
    .hdb_o (dec_hdb)
  );

  gsl_pwr u_pwr (
    .clk      (clk),
    .rst      (rst),
    .tx_s_i   (pins_s[3]),
    .awake_s_i(pins_s[4]),
    .mode_o   (mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_code_o <= CODE_W'(CODE_MIN);
      gain_hdb_o  <= RST_HDB;
      commit_o    <= 1'b0;
    end else begin
      commit_o <= commit_pulse;
      if (commit_pulse) begin
        gain_code_o <= dec_code;
        gain_hdb_o  <= dec_hdb;
      end
    end
  end

  assign pwr_mode_o = mode;

endmodule

// File: rtl/gsl_chk.sv
module gsl_chk #(
  parameter int CODE_W   = 6,
  parameter int CODE_MIN = 1,
  parameter int CODE_MAX = 60,
  parameter int HDB_W    = 8,
  parameter int HDB_OFS  = 53
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] gain_code_o,
  input logic [HDB_W-1:0]  gain_hdb_o,
  input logic              commit_o,
  input logic [1:0]        pwr_mode_o
);

  logic [HDB_W-1:0] hdb_expect;
  assign hdb_expect = HDB_W'(2 * int'(gain_code_o) - HDB_OFS);

  // R4 and R5: the committed code stays inside the legal range
  p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(gain_code_o) >= CODE_MIN) && (int'(gain_code_o) <= CODE_MAX));

  p_hdb_track_r6: assert property (@(posedge clk) disable iff (rst)
    gain_hdb_o == hdb_expect);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  p_hold_code_r9: assert property (@(posedge clk) disable iff (rst)
    !commit_o |-> $stable(gain_code_o));

  p_mode_legal_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_mode_o != 2'b11);

endmodule

bind gain_serial_loader gsl_chk #(
  .CODE_W  (CODE_W),
  .CODE_MIN(CODE_MIN),
  .CODE_MAX(CODE_MAX),
  .HDB_W   (HDB_W),
  .HDB_OFS (HDB_OFS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gain_code_o(gain_code_o),
  .gain_hdb_o (gain_hdb_o),
  .commit_o   (commit_o),
  .pwr_mode_o (pwr_mode_o)
);

// File: tb/gain_serial_loader_tb.sv
module gain_serial_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       load_n = 1'b1;
  logic       tx_on = 1'b0;
  logic       awake_n = 1'b0;
  logic [5:0] gain_code;
  logic [7:0] gain_hdb;
  logic       commit;
  logic [1:0] pwr_mode;

  int checks = 0;
  int errors = 0;
  int commit_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_serial_loader u_dut (
    .clk        (clk),
    .rst        (rst),
    .ser_clk_i  (ser_clk),
    .ser_dat_i  (ser_dat),
    .load_n_i   (load_n),
    .tx_on_i    (tx_on),
    .awake_n_i  (awake_n),
    .gain_code_o(gain_code),
    .gain_hdb_o (gain_hdb),
    .commit_o   (commit),
    .pwr_mode_o (pwr_mode)
  );

  always @(negedge clk) begin
    if (!rst && commit) commit_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input bit b);
    @(negedge clk);
    ser_dat = b;
    wait_clk(HALF_SCLK);
    ser_clk = 1'b1;
    wait_clk(HALF_SCLK);
    ser_clk = 1'b0;
  endtask

  task automatic commit_word();
    @(negedge clk);
    load_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic load_word(input logic [7:0] w);
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(4);
    for (int i = 7; i >= 0; i--) shift_bit(w[i]);
    commit_word();
  endtask

  task automatic expect_code(input string req, input int code);
    chk(req, int'(gain_code), code);
    chk(req, int'($signed(gain_hdb)), 2 * code - 53);
  endtask

  task automatic t_reset();
    chk("R1 code", int'(gain_code), 1);
    chk("R1 hdb", int'($signed(gain_hdb)), -51);
    chk("R1 strobe", int'(commit), 0);
    chk("R1 mode", int'(pwr_mode), 0);
  endtask

  task automatic t_basic();
    int c0;
    c0 = commit_cnt;
    load_word(8'd37);
    expect_code("R2 word37", 37);
    chk("R7 one strobe", commit_cnt - c0, 1);
    load_word(8'd60);
    expect_code("R6 top code", 60);
    load_word(8'd1);
    expect_code("R6 bottom code", 1);
  endtask

  task automatic t_mask();
    load_word(8'd75);
    expect_code("R3 word75", 11);
    load_word(8'd181);
    expect_code("R3 word181", 53);
  endtask

  task automatic t_saturate();
    for (int v = 61; v <= 63; v++) begin
      load_word(8'(v));
      expect_code("R4 clamp", 60);
    end
  endtask

  task automatic t_zero();
    load_word(8'd0);
    expect_code("R5 zero", 1);
    load_word(8'd64);
    expect_code("R5 word64", 1);
  endtask

  task automatic t_hold();
    logic [7:0] w;
    int c0;
    w = 8'd22;
    load_word(8'd9);
    c0 = commit_cnt;
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(4);
    for (int i = 7; i >= 4; i--) shift_bit(w[i]);
    chk("R9 mid word hold", int'(gain_code), 9);
    for (int i = 3; i >= 0; i--) shift_bit(w[i]);
    wait_clk(4);
    chk("R9 before rise", int'(gain_code), 9);
    chk("R7 no strobe while low", commit_cnt - c0, 0);
    commit_word();
    expect_code("R9 after rise", 22);
    chk("R7 strobe count", commit_cnt - c0, 1);
  endtask

  task automatic t_ignore();
    load_word(8'd44);
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    chk("R8 no commit from clocks", int'(gain_code), 44);
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(8);
    commit_word();
    expect_code("R8 shift reg untouched", 44);
  endtask

  task automatic t_long_word();
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    for (int i = 7; i >= 0; i--) shift_bit(8'd30 >> i);
    commit_word();
    expect_code("R2 last eight bits", 30);
  endtask

  task automatic t_power();
    int c0;
    c0 = commit_cnt;
    tx_on = 1'b1; awake_n = 1'b0; wait_clk(6);
    chk("R10 sleep priority", int'(pwr_mode), 0);
    awake_n = 1'b1; wait_clk(6);
    chk("R10 transmit", int'(pwr_mode), 2);
    tx_on = 1'b0; wait_clk(6);
    chk("R10 standby", int'(pwr_mode), 1);
    awake_n = 1'b0; wait_clk(6);
    chk("R10 sleep", int'(pwr_mode), 0);
    chk("R10 code untouched", int'(gain_code), 30);
    chk("R10 no strobe", commit_cnt - c0, 0);
  endtask

  initial begin
    wait_clk(5);
    @(negedge clk);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_basic();
    t_mask();
    t_saturate();
    t_zero();
    t_hold();
    t_ignore();
    t_long_word();
    t_power();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule